// File: doc/BRIEF.md
# PWM Duty Threshold Detector

This block watches a free-running PWM input on a system clock and decides, once per PWM cycle, whether the high time of the pulse is longer than a programmable number of clock counts. The count is normally set to about one tenth of the PWM period, so the result reads as "duty above roughly 10%" or "duty below it". The decision is not an average. Each synchronized rising edge starts a delay window. When the window runs out, the block registers the level of the input at that moment as the new result.

The window length depends on the current result. While the result is low the block uses a longer window, so a pulse must clearly exceed the threshold to raise it. While the result is high it uses a shorter window, so a pulse must clearly fall short to drop it. This hysteresis is in time rather than in amplitude, and it stops the output from flipping on alternate cycles when the pulse width sits right at the threshold. If no rising edge arrives for a programmable number of clocks, the input is taken to be static (0% or 100% duty) and the result follows its level. Every update comes with a one-clock strobe. An alarm flag marks a below-threshold result.

Top module: `pwm_duty_detect`

## Requirements
- R1: A synchronous active-low reset clears `duty_above`, `duty_alarm` and `dec_valid` to 0 and abandons any window in progress. No strobe follows until a new rising edge or an idle timeout occurs.
- R2: A rising edge of the synchronized input starts a window. Its length is `win_up_len` clock counts while `duty_above` is 0 and `win_dn_len` counts while it is 1. Both lengths are non-zero.
- R3: When a window expires, `duty_above` takes the synchronized input level. With the input passing through a two-flop synchronizer, a pulse held high for W clocks yields 1 exactly when W is greater than the window length.
- R4: Every update sets `duty_alarm` to the complement of the new `duty_above`. The two flags are never high together.
- R5: `dec_valid` is a one-clock pulse on each update, and `duty_above` changes only on a clock where `dec_valid` is 1. A window that is not aborted produces exactly one pulse.
- R6: Hysteresis: with `duty_above`=1, a pulse of width W where `win_dn_len` < W <= `win_up_len` leaves it at 1. With `duty_above`=0, the same pulse leaves it at 0.
- R7: A rising edge that arrives while a window is running aborts that window without an update and starts a new one.
- R8: If `idle_lim` clocks pass without a rising edge, the result is forced to the synchronized static level with a `dec_valid` pulse, and the idle count restarts. `idle_lim` is non-zero.
- R9: When a window expiry and an idle timeout fall on the same clock, the block makes a single update with a single `dec_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | Asynchronous PWM input |
| win_up_len | input | CW | Window length in clocks while the result is low |
| win_dn_len | input | CW | Window length in clocks while the result is high |
| idle_lim | input | IW | Clocks without a rising edge before a static-level update |
| duty_above | output | 1 | Registered result, 1 = duty above threshold |
| dec_valid | output | 1 | One-clock strobe on each update |
| duty_alarm | output | 1 | Below-threshold flag |

## Verification
A window expiry and an idle timeout can fall on the same clock. The idle count restarts at every rising edge, so the collision is provoked by setting `idle_lim` equal to `win_up_len` and sending a long pulse while the result is low. Both events then land on the clock `win_up_len` counts after the edge. The bench judges the outcome by counting strobes across the pulse: it expects exactly one, together with a high result and a cleared alarm.

// File: rtl/pwmd_pkg.sv
// Package: shared types for the PWM duty threshold detector.
// Assumes: nothing beyond IEEE 1800-2017.
package pwmd_pkg;
    // An update request: fire asks for an update, level is the value to store.
    typedef struct packed {
        logic fire;
        logic level;
    } pwmd_evt_t;
endpackage

// File: rtl/pwmd_sync.sv
// Module: pwmd_sync
// Brings the asynchronous PWM input into the clock domain through STAGES flops,
// then flags a rising edge of the synchronized level for one clock.
// Assumes: STAGES >= 2. The reset clears the whole chain, so a level that is
// high when reset is released shows up as a fresh rising edge.
module pwmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              lvl_d;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first capture flop of the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // later flops that let a metastable value settle
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // one clock of history on the synchronized level, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~lvl_d;
endmodule

// File: rtl/pwmd_window.sv
// Module: pwmd_window
// Delay window started by each rising edge. A rise loads the length. The
// expire flag is high on the clock whose end closes the window, so that
// window covers len clocks after the rise. A rise during a running window
// restarts it, and that clock gives no expiry.
// Assumes: len is non-zero. A zero length is treated as one clock.
module pwmd_window #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic [CW-1:0] len,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic          run;
    logic [CW-1:0] cnt;

    // load on a rise, count down while running, stop at the last clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (rise) begin
            run <= 1'b1;
            cnt <= (len == '0) ? ONE : len;
        end else if (run) begin
            if (cnt <= ONE) run <= 1'b0;
            else            cnt <= cnt - ONE;
        end
    end

    assign expire = run & ~rise & (cnt == ONE);
endmodule

// File: rtl/pwmd_idle.sv
// Module: pwmd_idle
// Counts clocks since the last rising edge and raises a one-clock timeout
// when lim clocks pass with no edge. The count then restarts, so a static
// input keeps producing timeouts at that interval.
// Assumes: lim is non-zero. With a zero limit the timeout fires on every clock.
module pwmd_idle #(
    parameter int IW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic [IW-1:0] lim,
    output logic          tmo
);
    logic [IW-1:0] icnt;
    logic [IW:0]   nxt;

    assign nxt = {1'b0, icnt} + {{IW{1'b0}}, 1'b1};
    assign tmo = ~rise & (nxt >= {1'b0, lim});

    // clock counter since the last edge, cleared by an edge or a timeout
    always_ff @(posedge clk) begin
        if (!rst_n)          icnt <= '0;
        else if (rise | tmo) icnt <= '0;
        else if (!nxt[IW])   icnt <= nxt[IW-1:0];
    end
endmodule

// File: rtl/pwmd_decide.sv
// Module: pwmd_decide
// Result register. A window expiry or an idle timeout stores the
// synchronized level, sets the alarm to its complement and strobes valid.
// When both arrive on the same clock they make a single update.
// Assumes: lvl is already synchronized to clk.
module pwmd_decide
    import pwmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic tmo,
    input  logic lvl,
    output logic above,
    output logic alarm,
    output logic valid
);
    pwmd_evt_t evt;

    // merge the two update sources into a single request
    always_comb begin
        evt.fire  = expire | tmo;
        evt.level = lvl;
    end

    // register the result, the alarm and the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above <= 1'b0;
            alarm <= 1'b0;
            valid <= 1'b0;
        end else begin
            valid <= evt.fire;
            if (evt.fire) begin
                above <= evt.level;
                alarm <= ~evt.level;
            end
        end
    end
endmodule

// File: rtl/pwm_duty_detect.sv
// Module: pwm_duty_detect (top)
// Per-cycle PWM duty threshold decision, with time-domain hysteresis. The
// window length follows the current result: win_up_len while it is low,
// win_dn_len while it is high.
// Assumes: win_dn_len < win_up_len for hysteresis, and both lengths and
// idle_lim are non-zero.
module pwm_duty_detect #(
    parameter int CW       = 16,
    parameter int IW       = 20,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_in,
    input  logic [CW-1:0] win_up_len,
    input  logic [CW-1:0] win_dn_len,
    input  logic [IW-1:0] idle_lim,
    output logic          duty_above,
    output logic          dec_valid,
    output logic          duty_alarm
);
    logic          sync_lvl;
    logic          sync_rise;
    logic          win_exp;
    logic          idle_tmo;
    logic [CW-1:0] win_len;

    // pick the window length from the present result
    assign win_len = duty_above ? win_dn_len : win_up_len;

    pwmd_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pwm_in),
        .lvl(sync_lvl), .rise(sync_rise)
    );

    pwmd_window #(.CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .rise(sync_rise),
        .len(win_len), .expire(win_exp)
    );

    pwmd_idle #(.IW(IW)) u_idle (
        .clk(clk), .rst_n(rst_n), .rise(sync_rise),
        .lim(idle_lim), .tmo(idle_tmo)
    );

    pwmd_decide u_dec (
        .clk(clk), .rst_n(rst_n), .expire(win_exp), .tmo(idle_tmo),
        .lvl(sync_lvl), .above(duty_above), .alarm(duty_alarm),
        .valid(dec_valid)
    );
endmodule

// File: rtl/pwmd_chk.sv
// Module: pwmd_chk
// Temporal checks on the detector, attached to the top with bind.
module pwmd_chk (
    input logic clk,
    input logic rst_n,
    input logic lvl,
    input logic above,
    input logic alarm,
    input logic valid
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!above && !alarm && !valid));

    // R4
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(above && alarm));

    // R4
    alarm_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (alarm == !above));

    // R5
    change_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (above != $past(above)) |-> valid);

    // R3
    sample_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (above == $past(lvl)));
endmodule

bind pwm_duty_detect pwmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl),
    .above(duty_above), .alarm(duty_alarm), .valid(dec_valid)
);

// File: tb/sim_pwm_duty_detect.sv
module sim_pwm_duty_detect;
    localparam int CW = 16;
    localparam int IW = 20;
    localparam int UP = 20;
    localparam int DN = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_in = 1'b0;
    logic [CW-1:0] win_up_len = CW'(UP);
    logic [CW-1:0] win_dn_len = CW'(DN);
    logic [IW-1:0] idle_lim = IW'(1000);
    logic          duty_above, dec_valid, duty_alarm;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt;
    bit exp_hi = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_duty_detect #(.CW(CW), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
        .win_up_len(win_up_len), .win_dn_len(win_dn_len), .idle_lim(idle_lim),
        .duty_above(duty_above), .dec_valid(dec_valid), .duty_alarm(duty_alarm)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected result of one pulse, from the requirements
    function automatic bit pred(input bit cur, input int w);
        return cur ? (w > DN) : (w > UP);
    endfunction

    // hold pwm at a level for n clocks, counting strobes at falling edges
    task automatic hold(input bit lv, input int n);
        pwm_in = lv;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dec_valid) vcnt++;
        end
    endtask

    // one pulse, checked for result, alarm and a single strobe
    task automatic pulse(input int w, input int lo, input string req);
        bit e;
        e = pred(exp_hi, w);
        vcnt = 0;
        hold(1'b1, w);
        hold(1'b0, lo);
        chk(duty_above == e, req, duty_above, e);
        chk(duty_alarm == !e, {req, "/R4"}, duty_alarm, !e);
        chk(vcnt == 1, {req, "/R5"}, vcnt, 1);
        exp_hi = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        vcnt = 0;
        hold(1'b0, 5);
        // R1 reset state, no strobe after release
        chk(duty_above == 0 && duty_alarm == 0, "R1 flags", {duty_above, duty_alarm}, 0);
        chk(vcnt == 0, "R1 strobe", vcnt, 0);

        // R3/R2 boundaries from low: window UP
        pulse(UP, 40, "R3 w=up");
        pulse(UP + 1, 40, "R3 w=up+1");
        // R2 boundaries from high: window DN
        pulse(DN + 1, 40, "R2 w=dn+1");
        pulse(DN, 40, "R2 w=dn");

        // R6 hysteresis from low, then from high
        for (int k = DN + 1; k <= UP; k++) pulse(k, 40, "R6 stay low");
        pulse(UP + 5, 40, "R6 raise");
        for (int k = DN + 1; k <= UP; k++) pulse(k, 40, "R6 stay high");

        // R7 restart: short glitch then a long pulse, one strobe only
        pulse(DN, 40, "R7 prep");
        vcnt = 0;
        hold(1'b1, 2); hold(1'b0, 3); hold(1'b1, UP + 4); hold(1'b0, 40);
        chk(vcnt == 1, "R7 strobes", vcnt, 1);
        chk(duty_above == 1, "R7 result", duty_above, 1);
        exp_hi = 1'b1;
        vcnt = 0;
        hold(1'b1, 2); hold(1'b0, 3); hold(1'b1, 5); hold(1'b0, 40);
        chk(vcnt == 1, "R7 strobes b", vcnt, 1);
        chk(duty_above == 0, "R7 result b", duty_above, 0);
        exp_hi = 1'b0;

        // random pulses
        for (int k = 0; k < 40; k++) begin
            int w, lo;
            w  = 1 + int'($urandom % 36);
            lo = 30 + int'($urandom % 20);
            pulse(w, lo, "R3 random");
        end

        // R8 idle timeouts with a static level
        idle_lim = IW'(50);
        vcnt = 0;
        hold(1'b1, 130);
        chk(duty_above == 1 && duty_alarm == 0, "R8 static high", duty_above, 1);
        chk(vcnt >= 2, "R8 strobes high", vcnt, 2);
        vcnt = 0;
        hold(1'b0, 130);
        chk(duty_above == 0 && duty_alarm == 1, "R8 static low", duty_alarm, 1);
        chk(vcnt >= 2, "R8 strobes low", vcnt, 2);

        // R9 window expiry and timeout on the same clock
        idle_lim = IW'(UP);
        hold(1'b0, 30);
        vcnt = 0;
        hold(1'b1, 30);
        chk(vcnt == 1, "R9 single strobe", vcnt, 1);
        chk(duty_above == 1 && duty_alarm == 0, "R9 result", duty_above, 1);
        idle_lim = IW'(1000);
        hold(1'b0, 40);
        exp_hi = duty_above;

        // R1 reset in the middle of a window
        pulse(UP + 10, 40, "R1 prep");
        hold(1'b1, 5);
        rst_n = 1'b0;
        pwm_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        vcnt = 0;
        hold(1'b0, 30);
        chk(duty_above == 0 && duty_alarm == 0, "R1 mid-window", duty_above, 0);
        chk(vcnt == 0, "R1 no strobe", vcnt, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule